// File: doc/BRIEF.md
# Serial Clock-Disable Mask Loader

This block holds a 16-bit control word that decides which downstream bus clocks run. While the downstream bus is held in reset, a board-level agent can toggle two general-purpose I/O lines and a dedicated mask-data line to shift a new word in one bit at a time. A second step then copies that word into the control register. One GPIO line is the shift clock and the other selects between shifting and loading.

The control word is split into 2-bit fields, one per downstream clock. A clock whose field is `11` gets its enable pulled low, and an external gating cell then holds that clock at 0. Any other field value leaves the clock running. The register can also be read and written through a plain configuration port at any time. Once the downstream reset is released, the serial lines have no further effect.

All serial inputs are asynchronous to the block clock. They pass through a synchronizer, and edges of the shift clock are detected in the block clock domain. The configuration port has no back-pressure. A write strobe is accepted in the cycle it is presented, and the read data always reflects the current register value.

Top module: `clkmask_loader`

## Requirements
- R1: After power-on reset (`rst_n` low) the control register reads 0, and every bit of `clk_en` is 1.
- R2: While `sec_rst_n` is low, each rising edge of `gpio_sclk` with `gpio_sel` high shifts `mask_in` into a 16-bit shift register, least significant bit first. After 16 such edges, the first bit sent sits at bit 0. A shift clock that stays high causes no further shifts.
- R3: While `sec_rst_n` is low, a rising edge of `gpio_sclk` with `gpio_sel` low copies the shift register into the control register. The shift register keeps its contents, so a second load without new shifts gives the same value. After power-on reset the shift register is 0.
- R4: Clock output i uses control bits 2i (low) and 2i+1 (high). `clk_en[i]` is 0 exactly when both bits are 1; field values 00, 01 and 10 keep it at 1.
- R5: While `sec_rst_n` is high, activity on `gpio_sclk`, `gpio_sel` and `mask_in` changes neither `cfg_rdata` nor `clk_en`.
- R6: When `cfg_we` is high at a clock edge, `cfg_wdata` is written to the control register. This works whatever the state of `sec_rst_n`, and the new value is seen on `cfg_rdata` after that edge. If a configuration write and a serial load land on the same edge, the configuration write wins.
- R7: With the default two synchronizer stages, a load takes effect on the third block-clock edge after `gpio_sclk` rises, and not on an earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| sec_rst_n | input | 1 | Downstream bus reset, active low; serial loading is allowed while it is low |
| gpio_sclk | input | 1 | Serial shift clock taken from a GPIO line (asynchronous) |
| gpio_sel | input | 1 | GPIO line: 1 means shift, 0 means load on the next shift-clock rise |
| mask_in | input | 1 | Serial mask data bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Current control register value |
| clk_en | output | 8 | Per-clock enable; 0 means the clock is held low |

## Verification
Most internal faults show up on `cfg_rdata` within a few cycles of the load that exposes them. A bad shift register or bit order appears as a permuted or shifted word on `cfg_rdata`, on the third clock edge after the load rise. A wrong field decode appears only on `clk_en`, and only for the field value `11` or for the two bit positions of one field. A window check that leaks lets the word on `cfg_rdata` change after `sec_rst_n` rises, which is visible right after the next serial load.

// File: rtl/clkmask_pkg.sv
package clkmask_pkg;
  localparam int unsigned FIELD_W = 2;
  localparam logic [FIELD_W-1:0] FIELD_OFF = '1;
endpackage

// File: rtl/cm_sync.sv
module cm_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[k] <= '0;
      else        st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cm_shifter.sv
module cm_shifter #(
  parameter int unsigned MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_pulse,
  input  logic              din,
  output logic [MASK_W-1:0] shift_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           shift_q <= '0;
    else if (shift_pulse) shift_q <= {din, shift_q[MASK_W-1:1]};
  end

  // R2: new bit enters at the top, older bits move one place toward bit 0
  assert_shift_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> (shift_q[MASK_W-1] == $past(din)) &&
                    (shift_q[MASK_W-2:0] == $past(shift_q[MASK_W-1:1])));

  assert_shift_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_pulse |=> $stable(shift_q));
endmodule

// File: rtl/cm_ctrl_reg.sv
module cm_ctrl_reg #(
  parameter int unsigned MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_pulse,
  input  logic [MASK_W-1:0] load_val,
  input  logic              cfg_we,
  input  logic [MASK_W-1:0] cfg_wdata,
  output logic [MASK_W-1:0] ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ctrl_q <= '0;
    else if (cfg_we)     ctrl_q <= cfg_wdata;
    else if (load_pulse) ctrl_q <= load_val;
  end

  assert_cfg_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ctrl_q == $past(cfg_wdata));

  assert_serial_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && !cfg_we) |=> ctrl_q == $past(load_val));

  assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_pulse && !cfg_we) |=> $stable(ctrl_q));
endmodule

// File: rtl/cm_decode.sv
module cm_decode #(
  parameter int unsigned NUM_CLK = 8
) (
  input  logic [2*NUM_CLK-1:0] ctrl,
  output logic [NUM_CLK-1:0]   clk_en
);
  import clkmask_pkg::*;

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_field
    assign clk_en[i] = (ctrl[FIELD_W*i +: FIELD_W] != FIELD_OFF);
  end
endmodule

// File: rtl/clkmask_loader.sv
module clkmask_loader #(
  parameter int unsigned MASK_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_CLK    = MASK_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_rst_n,
  input  logic              gpio_sclk,
  input  logic              gpio_sel,
  input  logic              mask_in,
  input  logic              cfg_we,
  input  logic [MASK_W-1:0] cfg_wdata,
  output logic [MASK_W-1:0] cfg_rdata,
  output logic [NUM_CLK-1:0] clk_en
);
  logic [2:0]        pins_s;
  logic              sclk_s, sel_s, din_s, sclk_d;
  logic              rise, window, shift_pulse, load_pulse;
  logic [MASK_W-1:0] shift_q, ctrl_q;

  cm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({gpio_sclk, gpio_sel, mask_in}), .q(pins_s));

  assign {sclk_s, sel_s, din_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign rise        = sclk_s & ~sclk_d;
  assign window      = ~sec_rst_n;
  assign shift_pulse = rise & sel_s & window;
  assign load_pulse  = rise & ~sel_s & window;

  cm_shifter #(.MASK_W(MASK_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_pulse(shift_pulse),
    .din(din_s), .shift_q(shift_q));

  cm_ctrl_reg #(.MASK_W(MASK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_pulse(load_pulse), .load_val(shift_q),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q));

  cm_decode #(.NUM_CLK(NUM_CLK)) u_dec (.ctrl(ctrl_q), .clk_en(clk_en));

  assign cfg_rdata = ctrl_q;

  assert_no_serial_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_rst_n && !cfg_we) |=> $stable(cfg_rdata) && $stable(clk_en));

  assert_one_action_per_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({shift_pulse, load_pulse}) <= 1);

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_chk
    assert_off_needs_both_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en[i] |-> cfg_rdata[2*i +: 2] == 2'b11);
  end
endmodule

// File: tb/sim_clkmask_loader.sv
module sim_clkmask_loader;
  localparam int PERIOD = 10;
  localparam int MW = 16;
  localparam int NC = MW / 2;

  logic clk = 0, rst_n = 0, sec_rst_n = 0;
  logic gpio_sclk = 0, gpio_sel = 1, mask_in = 0, cfg_we = 0;
  logic [MW-1:0] cfg_wdata = '0;
  logic [MW-1:0] cfg_rdata;
  logic [NC-1:0] clk_en;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  clkmask_loader u0 (.clk(clk), .rst_n(rst_n), .sec_rst_n(sec_rst_n),
    .gpio_sclk(gpio_sclk), .gpio_sel(gpio_sel), .mask_in(mask_in),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .clk_en(clk_en));

  function automatic logic [NC-1:0] exp_en(input logic [MW-1:0] p);
    logic [NC-1:0] e;
    for (int i = 0; i < NC; i++) e[i] = !(p[2*i] && p[2*i+1]);
    return e;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [MW-1:0] exp_r);
    checks++;
    if (cfg_rdata !== exp_r || clk_en !== exp_en(exp_r)) begin
      fails++;
      $display("FAIL %s rdata=%h en=%b expected rdata=%h en=%b",
               req, cfg_rdata, clk_en, exp_r, exp_en(exp_r));
    end
  endtask

  task automatic shift_word(input logic [MW-1:0] p);
    for (int b = 0; b < MW; b++) begin
      gpio_sel = 1; mask_in = p[b]; gpio_sclk = 0; tick(4);
      gpio_sclk = 1; tick(4);
    end
  endtask

  task automatic load_word();
    gpio_sel = 0; gpio_sclk = 0; tick(4);
    gpio_sclk = 1; tick(4);
    gpio_sclk = 0; tick(4);
  endtask

  task automatic cfg_write(input logic [MW-1:0] v);
    cfg_wdata = v; cfg_we = 1; tick(1); cfg_we = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [MW-1:0] p, prev;
    tick(5); rst_n = 1; tick(2);
    chk("R1 reset state", '0);
    load_word();
    chk("R3 load of cleared shift register", '0);

    // R4: every field of every clock, through configuration writes
    for (int i = 0; i < NC; i++)
      for (int v = 0; v < 4; v++) begin
        cfg_write(MW'(v) << (2*i));
        chk("R4 field decode", MW'(v) << (2*i));
      end
    cfg_write('0);

    // R2/R3: serial patterns
    for (int k = 0; k < 12; k++) begin
      p = MW'((k * 40503) ^ (k << 5) ^ (k == 11 ? 16'hFFFF : 16'h0));
      shift_word(p);
      load_word();
      chk("R2 serial shift and load", p);
    end
    prev = cfg_rdata;

    // R7: load latency
    p = 16'hC3A5;
    shift_word(p);
    gpio_sel = 0; gpio_sclk = 0; tick(4);
    gpio_sclk = 1; tick(2);
    chk("R7 not before third edge", prev);
    tick(1);
    chk("R7 on third edge", p);
    gpio_sclk = 0; tick(4);

    // R3: repeated load keeps the shift register
    cfg_write(16'h0001);
    load_word();
    chk("R3 second load same value", p);

    // R6: collision, configuration write wins
    shift_word(16'h5A5A);
    gpio_sel = 0; gpio_sclk = 0; tick(4);
    gpio_sclk = 1; tick(2);
    cfg_wdata = 16'h0F0F; cfg_we = 1; tick(1); cfg_we = 0;
    chk("R6 config write over load", 16'h0F0F);
    gpio_sclk = 0; tick(4);

    // R5: serial lines ignored after release
    cfg_write(16'h3C00);
    sec_rst_n = 1; tick(2);
    shift_word(16'hFFFF);
    load_word();
    chk("R5 serial ignored after release", 16'h3C00);
    cfg_write(16'hFFFF);
    chk("R6 config write after release", 16'hFFFF);
    shift_word(16'h0000);
    load_word();
    chk("R5 serial ignored after release 2", 16'hFFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule